// File: doc/BRIEF.md
# Single and Cross-Cycle Implication Checker

This block watches a vector of internal signal sites of some host sequential logic and checks, every clock, a list of logic implications among those sites. Each implication names an antecedent site with the value that triggers it and a consequent site with the value it must then carry. An implication is either same-cycle, where both sites are compared in one clock, or cross-cycle, where the antecedent is taken in one clock and the consequent in the next. A mismatch on a triggered implication is a runtime error in the host logic. One implication often exposes faults at several places in the host, so the number of implications is a parameter that trades error coverage against area.

The implication list is fixed by parameters at build time. Each entry has an 8-bit antecedent index (field i of `ANT_IDX` sits at bits `[8*i+7 : 8*i]`), an antecedent value (bit i of `ANT_VAL`), an 8-bit consequent index (field i of `CON_IDX`), a consequent value (bit i of `CON_VAL`) and a cross-cycle flag (bit i of `CROSS`, 1 = cross-cycle). The consequent may be any site, upstream or downstream of the antecedent. Cross-cycle lanes keep the antecedent match in a flip-flop for one clock.

Two small state machines sit beside the lanes. The history machine has the states `HIST_COLD` and `HIST_PRIMED`: reset puts it in `HIST_COLD`, a valid cycle moves it from `HIST_COLD` to `HIST_PRIMED`, a cycle with `valid` low returns it from `HIST_PRIMED` to `HIST_COLD`, and cross-cycle lanes may only report in `HIST_PRIMED`. The flag machine has the states `FLAG_CLEAR` and `FLAG_LATCHED`: any violation moves it from `FLAG_CLEAR` to `FLAG_LATCHED`, and only reset leaves `FLAG_LATCHED`.

The default build has 8 sites and 6 implications: lane 0 is s0=1 implies s3=0, lane 1 is s1=0 implies s2=0, lane 2 is s4=1 implies s5=1 (all same-cycle); lane 3 is s2=0 implies s6=0 next cycle, lane 4 is s7=1 implies s0=1 next cycle, lane 5 is s5=1 implies s1=0 next cycle (all cross-cycle).

Top module: `impl_guard`

## Requirements
- R1: For a same-cycle lane i, `viol[i]` is 1 in the same cycle exactly when `valid` is 1, the antecedent site equals its required value and the consequent site differs from its required value.
- R2: Every pairing of antecedent and consequent values (1 then 0, 0 then 0, 1 then 1, 0 then 1) is checked with the polarity given by `ANT_VAL` and `CON_VAL`.
- R3: For a cross-cycle lane i, `viol[i]` is 1 in cycle t+1 exactly when cycles t and t+1 are both valid, the antecedent matched in cycle t and the consequent mismatches in cycle t+1; the consequent may have a lower site index than the antecedent.
- R4: Cross-cycle lanes report nothing in the first valid cycle after reset or after any cycle with `valid` low; an antecedent captured in that first valid cycle is checked in the following cycle.
- R5: In a cycle with `valid` low the sampled sites are ignored and `viol` is all zero; the next `err_pulse` is 0.
- R6: `err_pulse` is 1 in the cycle after any bit of `viol` was 1 and 0 in the cycle after `viol` was all zero.
- R7: `err_sticky` becomes 1 one clock after the first violation and stays 1 until reset.
- R8: `first_idx` holds the lowest set bit index of `viol` in the cycle that first set `err_sticky`, and does not change on later violations.
- R9: After reset `err_pulse` is 0, `err_sticky` is 0 and `first_idx` is 0.
- R10: A valid cycle in which no triggered implication has a mismatching consequent gives `viol` all zero and no error.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| valid | input | 1 | Site vector is meaningful this cycle |
| sites | input | SITE_W | Sampled site values |
| viol | output | N_IMP | Per-implication violation, same cycle as the check |
| err_pulse | output | 1 | Registered OR of `viol` |
| err_sticky | output | 1 | Latched error flag, cleared by reset only |
| first_idx | output | IDX_W | Lowest violated lane in the cycle that latched the flag |

## Verification
A wrong history state shows up on `viol` of the cross-cycle lanes in the very cycle it matters: a history machine left primed across a gap in `valid` raises a cross-cycle violation in the first valid cycle after the gap, while a lost antecedent flop hides the violation expected one clock after its antecedent. A wrong flag state shows on `err_sticky` one clock after the violation, and a wrong capture of the index shows on `first_idx` at the same edge and keeps showing because it is held. The directed scenarios drive antecedents into invalid cycles and follow them with consequent mismatches so that these faults reach the ports within two clocks.

// File: rtl/impl_pkg.sv
package impl_pkg;

    // Width of one site-index field in the packed implication parameters
    localparam int unsigned FIELD_W = 8;

    typedef enum logic {
        HIST_COLD   = 1'b0,
        HIST_PRIMED = 1'b1
    } hist_state_t;

    typedef enum logic {
        FLAG_CLEAR   = 1'b0,
        FLAG_LATCHED = 1'b1
    } flag_state_t;

endpackage

// File: rtl/impl_probe.sv
// Compares one antecedent and one consequent site against their required values.
module impl_probe #(
    parameter int unsigned SITE_W = 8,
    parameter int unsigned ANT_I  = 0,
    parameter bit          ANT_V  = 1'b1,
    parameter int unsigned CON_I  = 1,
    parameter bit          CON_V  = 1'b0
) (
    input  logic [SITE_W-1:0] sites,
    output logic              ant_hit,
    output logic              con_miss
);

    assign ant_hit  = (sites[ANT_I] == ANT_V);
    assign con_miss = (sites[CON_I] != CON_V);

endmodule

// File: rtl/impl_lowest.sv
// Finds the lowest set bit of a request vector.
module impl_lowest #(
    parameter int unsigned N  = 6,
    parameter int unsigned IW = 3
) (
    input  logic [N-1:0]  req,
    output logic [IW-1:0] idx,
    output logic          any
);

    always_comb begin
        idx = '0;
        for (int k = N - 1; k >= 0; k--) begin
            if (req[k]) begin
                idx = IW'(k);
            end
        end
    end

    assign any = |req;

endmodule

// File: rtl/impl_guard.sv
module impl_guard
    import impl_pkg::*;
#(
    parameter int unsigned SITE_W = 8,
    parameter int unsigned N_IMP  = 6,
    parameter logic [N_IMP*FIELD_W-1:0] ANT_IDX = {8'd5, 8'd7, 8'd2, 8'd4, 8'd1, 8'd0},
    parameter logic [N_IMP-1:0]         ANT_VAL = 6'b110101,
    parameter logic [N_IMP*FIELD_W-1:0] CON_IDX = {8'd1, 8'd0, 8'd6, 8'd5, 8'd2, 8'd3},
    parameter logic [N_IMP-1:0]         CON_VAL = 6'b010100,
    parameter logic [N_IMP-1:0]         CROSS   = 6'b111000,
    localparam int unsigned IDX_W = (N_IMP > 1) ? $clog2(N_IMP) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              valid,
    input  logic [SITE_W-1:0] sites,
    output logic [N_IMP-1:0]  viol,
    output logic              err_pulse,
    output logic              err_sticky,
    output logic [IDX_W-1:0]  first_idx
);

    hist_state_t hist_q, hist_d;
    flag_state_t flag_q, flag_d;

    logic             primed;
    logic [IDX_W-1:0] low_idx;
    logic             any_viol;
    logic             err_pulse_q;
    logic [IDX_W-1:0] first_idx_q;

    assign primed = (hist_q == HIST_PRIMED);

    // One lane per implication; the cross flag picks the same-cycle or delayed variant
    for (genvar i = 0; i < N_IMP; i++) begin : g_lane
        logic ant_hit;
        logic con_miss;

        impl_probe #(
            .SITE_W (SITE_W),
            .ANT_I  (int'(ANT_IDX[i*FIELD_W +: FIELD_W])),
            .ANT_V  (ANT_VAL[i]),
            .CON_I  (int'(CON_IDX[i*FIELD_W +: FIELD_W])),
            .CON_V  (CON_VAL[i])
        ) u_probe (
            .sites    (sites),
            .ant_hit  (ant_hit),
            .con_miss (con_miss)
        );

        if (CROSS[i]) begin : g_cross
            logic ant_q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    ant_q <= 1'b0;
                end else begin
                    ant_q <= ant_hit;
                end
            end
            assign viol[i] = valid & primed & ant_q & con_miss;
        end else begin : g_same
            assign viol[i] = valid & ant_hit & con_miss;
        end
    end

    impl_lowest #(
        .N  (N_IMP),
        .IW (IDX_W)
    ) u_lowest (
        .req (viol),
        .idx (low_idx),
        .any (any_viol)
    );

    // State registers
    always_ff @(posedge clk) begin
        if (rst) begin
            hist_q <= HIST_COLD;
            flag_q <= FLAG_CLEAR;
        end else begin
            hist_q <= hist_d;
            flag_q <= flag_d;
        end
    end

    // Next-state logic
    always_comb begin
        hist_d = hist_q;
        unique case (hist_q)
            HIST_COLD:   if (valid)  hist_d = HIST_PRIMED;
            HIST_PRIMED: if (!valid) hist_d = HIST_COLD;
            default:     hist_d = HIST_COLD;
        endcase

        flag_d = flag_q;
        unique case (flag_q)
            FLAG_CLEAR:   if (any_viol) flag_d = FLAG_LATCHED;
            FLAG_LATCHED: flag_d = FLAG_LATCHED;
            default:      flag_d = FLAG_CLEAR;
        endcase
    end

    // Output registers
    always_ff @(posedge clk) begin
        if (rst) begin
            err_pulse_q <= 1'b0;
            first_idx_q <= '0;
        end else begin
            err_pulse_q <= any_viol;
            if ((flag_q == FLAG_CLEAR) && any_viol) begin
                first_idx_q <= low_idx;
            end
        end
    end

    assign err_pulse  = err_pulse_q;
    assign err_sticky = (flag_q == FLAG_LATCHED);
    assign first_idx  = first_idx_q;

endmodule

// File: rtl/impl_guard_chk.sv
module impl_guard_chk #(
    parameter int unsigned N_IMP = 6,
    parameter int unsigned IDX_W = 3,
    parameter logic [N_IMP-1:0] CROSS = '0
) (
    input logic             clk,
    input logic             rst,
    input logic             valid,
    input logic [N_IMP-1:0] viol,
    input logic             err_pulse,
    input logic             err_sticky,
    input logic [IDX_W-1:0] first_idx
);

    logic [N_IMP-1:0] viol_d;
    logic             idx_sel;
    logic             idx_lower_clear;

    always_ff @(posedge clk) begin
        if (rst) viol_d <= '0;
        else     viol_d <= viol;
    end

    always_comb begin
        idx_sel         = 1'b0;
        idx_lower_clear = 1'b1;
        for (int k = 0; k < N_IMP; k++) begin
            if (IDX_W'(k) == first_idx) idx_sel = viol_d[k];
            if (IDX_W'(k) < first_idx && viol_d[k]) idx_lower_clear = 1'b0;
        end
    end

    AST_QUIET_WHEN_INVALID: assert property (@(posedge clk) disable iff (rst) !valid |-> (viol == '0)); // R5
    AST_CROSS_COLD_AFTER_GAP: assert property (@(posedge clk) disable iff (rst) !$past(valid) |-> ((viol & CROSS) == '0)); // R4
    AST_CROSS_COLD_AFTER_RESET: assert property (@(posedge clk) disable iff (rst) $past(rst) |-> ((viol & CROSS) == '0)); // R4
    AST_PULSE_ON_VIOL: assert property (@(posedge clk) disable iff (rst) (|viol) |=> err_pulse); // R6
    AST_PULSE_QUIET: assert property (@(posedge clk) disable iff (rst) !(|viol) |=> !err_pulse); // R6
    AST_STICKY_HOLDS: assert property (@(posedge clk) disable iff (rst) err_sticky |=> err_sticky); // R7
    AST_STICKY_NEEDS_VIOL: assert property (@(posedge clk) disable iff (rst) $rose(err_sticky) |-> err_pulse); // R7
    AST_IDX_LOWEST: assert property (@(posedge clk) disable iff (rst) $rose(err_sticky) |-> (idx_sel && idx_lower_clear)); // R8
    AST_IDX_HELD: assert property (@(posedge clk) disable iff (rst) err_sticky |=> $stable(first_idx)); // R8

endmodule

bind impl_guard impl_guard_chk #(
    .N_IMP (N_IMP),
    .IDX_W (IDX_W),
    .CROSS (CROSS)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .valid      (valid),
    .viol       (viol),
    .err_pulse  (err_pulse),
    .err_sticky (err_sticky),
    .first_idx  (first_idx)
);

// File: tb/tb_impl_guard.sv
module tb_impl_guard;

    localparam int CLK_PERIOD = 10;
    localparam int SW = 8;
    localparam int N  = 6;
    localparam logic [SW-1:0] QUIET = 8'h06;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          valid = 1'b0;
    logic [SW-1:0] sites = QUIET;
    logic [N-1:0]  viol;
    logic          err_pulse;
    logic          err_sticky;
    logic [2:0]    first_idx;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    impl_guard dut (
        .clk        (clk),
        .rst        (rst),
        .valid      (valid),
        .sites      (sites),
        .viol       (viol),
        .err_pulse  (err_pulse),
        .err_sticky (err_sticky),
        .first_idx  (first_idx)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; valid = 1'b0; sites = QUIET;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        chk(err_pulse == 1'b0,  "R9 err_pulse",  64'(err_pulse),  64'd0);
        chk(err_sticky == 1'b0, "R9 err_sticky", 64'(err_sticky), 64'd0);
        chk(first_idx == 3'd0,  "R9 first_idx",  64'(first_idx),  64'd0);
    endtask

    // Drive one cycle at the falling edge and check the same-cycle violation vector
    task automatic step(input bit v, input logic [SW-1:0] s, input logic [N-1:0] exp_v, input string tag);
        @(negedge clk);
        valid = v; sites = s;
        #1;
        chk(viol == exp_v, tag, 64'(viol), 64'(exp_v));
    endtask

    // Check the registered outputs just after the next rising edge
    task automatic edge_chk(input bit exp_p, input bit exp_s, input logic [2:0] exp_i);
        @(posedge clk);
        #1;
        chk(err_pulse == exp_p,  "R6 err_pulse",  64'(err_pulse),  64'(exp_p));
        chk(err_sticky == exp_s, "R7 err_sticky", 64'(err_sticky), 64'(exp_s));
        chk(first_idx == exp_i,  "R8 first_idx",  64'(first_idx),  64'(exp_i));
    endtask

    task automatic t_reset_quiet();
        do_reset();
        step(1'b1, QUIET, 6'b000000, "R10 quiet vector");
        edge_chk(1'b0, 1'b0, 3'd0);
    endtask

    task automatic t_same_cycle();
        do_reset();
        step(1'b1, 8'h0F, 6'b000001, "R1 lane0 s0=1 s3=1");
        edge_chk(1'b1, 1'b1, 3'd0);
    endtask

    task automatic t_polarity();
        do_reset();
        step(1'b1, 8'h07, 6'b000000, "R10 s0=1 s3=0 holds");
        edge_chk(1'b0, 1'b0, 3'd0);
        step(1'b1, 8'h04, 6'b000010, "R2 lane1 0->0 violated");
        edge_chk(1'b1, 1'b1, 3'd1);
        step(1'b1, 8'h16, 6'b000100, "R2 lane2 1->1 violated");
        edge_chk(1'b1, 1'b1, 3'd1);
        step(1'b1, QUIET, 6'b000000, "R10 back to quiet");
        edge_chk(1'b0, 1'b1, 3'd1);
    endtask

    task automatic t_lowest_index();
        do_reset();
        step(1'b1, 8'h14, 6'b000110, "R8 lanes 1 and 2 together");
        edge_chk(1'b1, 1'b1, 3'd1);
        step(1'b1, 8'h0F, 6'b000001, "R1 later lane0 violation");
        edge_chk(1'b1, 1'b1, 3'd1);
        step(1'b1, QUIET, 6'b000000, "R7 quiet after latch");
        edge_chk(1'b0, 1'b1, 3'd1);
        do_reset();
    endtask

    task automatic t_cross_cycle();
        do_reset();
        step(1'b1, QUIET, 6'b000000, "R3 warm-up");
        step(1'b1, 8'h86, 6'b000000, "R3 s7=1 antecedent");
        step(1'b1, QUIET, 6'b010000, "R3 lane4 upstream s0=0");
        edge_chk(1'b1, 1'b1, 3'd4);
        step(1'b1, 8'h02, 6'b000000, "R3 s2=0 antecedent");
        step(1'b1, 8'h46, 6'b001000, "R3 lane3 s6=1");
        step(1'b1, 8'h26, 6'b000000, "R3 s5=1 antecedent");
        step(1'b1, QUIET, 6'b100000, "R3 lane5 s1=1");
        edge_chk(1'b1, 1'b1, 3'd4);
    endtask

    task automatic t_invalid_gap();
        do_reset();
        step(1'b0, 8'h0F, 6'b000000, "R5 invalid with lane0 pattern");
        edge_chk(1'b0, 1'b0, 3'd0);
        step(1'b0, 8'h86, 6'b000000, "R5 invalid with s7=1");
        step(1'b1, QUIET, 6'b000000, "R4 stale antecedent suppressed");
        edge_chk(1'b0, 1'b0, 3'd0);
        step(1'b0, QUIET, 6'b000000, "R5 second gap");
        step(1'b1, 8'h86, 6'b000000, "R4 first valid after gap");
        step(1'b1, QUIET, 6'b010000, "R4 antecedent from first valid cycle");
        edge_chk(1'b1, 1'b1, 3'd4);
    endtask

    initial begin
        t_reset_quiet();
        t_same_cycle();
        t_polarity();
        t_lowest_index();
        t_cross_cycle();
        t_invalid_gap();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
            $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

endmodule